// File: doc/BRIEF.md
# Packed Lane Saturating Adder

This block adds or subtracts two 64-bit words that are treated as a row of independent integer lanes. A two-bit select chooses the lane width at run time: eight byte lanes, four 16-bit lanes, two 32-bit lanes, or one 64-bit lane. Carries stop at every lane edge, so each lane of the result depends only on the same lane of the two operands.

Three single-bit controls shape the arithmetic: subtract instead of add, signed instead of unsigned, and clamp instead of wrap. When clamping is on and a lane leaves its range, that lane is held at the nearest limit for its width and sign mode. A flag is raised for every byte position that the clamped lane covers. The result and the flags are registered and appear one clock after an accepted input. This suits pixel and sample streams, where a value that wraps would flip from bright to dark.

Top module: `simd_sat_adder`

## Requirements
- R1: The lane select `lane_sel` picks 2'b00 for 8-bit lanes, 2'b01 for 16-bit, 2'b10 for 32-bit and 2'b11 for one 64-bit lane. Lane i sits at bits [i*W +: W]. No carry or borrow passes from one lane into the next.
- R2: With `sat_en` low, every lane result is the sum or difference modulo 2^W.
- R3: With `sat_en` and `signed_en` high, a lane result above 2^(W-1)-1 becomes 2^(W-1)-1, and a result below -2^(W-1) becomes -2^(W-1). For byte lanes these limits are +127 and -128.
- R4: With `sat_en` high and `signed_en` low, an add that exceeds 2^W-1 gives all ones in the lane. A subtract with b greater than a gives zero in the lane.
- R5: A saturating lane that stays within its range gives the same value as modulo arithmetic, and its flag is clear.
- R6: With `lane_sel` = 2'b11 the word is one 64-bit lane that always wraps. `sat_flag` stays zero there, whatever `sat_en` is.
- R7: `sat_flag` bit k is set when the lane that holds byte k (bits [8k+7:8k]) was clamped. Every byte of a wider lane carries the same flag. All flags are zero when `sat_en` is low.
- R8: With `sub_en` high each lane computes a minus b, formed as a + ~b + 1 within the lane.
- R9: When `in_valid` is high at a clock edge, `out_valid` is high after that edge, with the result in `out_data`. Otherwise `out_valid` goes low and `out_data` and `sat_flag` keep their values.
- R10: While `rst_n` is low, `out_valid`, `out_data` and `sat_flag` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 64 | First operand word |
| op_b | input | 64 | Second operand word |
| lane_sel | input | 2 | Lane width select (R1 encoding) |
| sub_en | input | 1 | 1 = a minus b, 0 = a plus b |
| signed_en | input | 1 | 1 = two's-complement lanes, 0 = unsigned |
| sat_en | input | 1 | 1 = clamp on overflow, 0 = wrap |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 64 | Registered packed result |
| sat_flag | output | 8 | Per-byte clamp flags |

## Verification
The assertions expect the controls to be stable in the cycle where `in_valid` is high, and every control to be a known 0 or 1. The bench drives all inputs on the falling edge, so they hold steady through the next rising edge. The sweep covers every combination of lane select, operation, sign mode and clamp mode. For each combination it runs extreme operand values (zero, all ones, most positive and most negative per lane) and pseudo-random words. It holds `in_valid` low between operations, so the checks of the idle hold see genuine gaps.

// File: rtl/simd_pkg.sv
package simd_pkg;

  localparam int SEG_W = 8;

  typedef enum logic [1:0] {
    LW_B8  = 2'b00,
    LW_B16 = 2'b01,
    LW_B32 = 2'b10,
    LW_B64 = 2'b11
  } lane_w_e;

  // Low index bits that stay inside one lane, for nseg byte segments.
  function automatic int span_mask(input logic [1:0] ls, input int nseg);
    case (ls)
      LW_B8:   return 0;
      LW_B16:  return 1;
      LW_B32:  return 3;
      default: return nseg - 1;
    endcase
  endfunction

  // The value a byte takes when its lane is clamped.
  function automatic logic [SEG_W-1:0] clamp_byte(
      input logic [SEG_W-1:0] raw,
      input logic             is_top,
      input logic             sgn,
      input logic             sub,
      input logic             neg_side,
      input logic             hit);
    logic [SEG_W-1:0] v;
    if (!hit) begin
      v = raw;
    end else if (sgn) begin
      if (neg_side) v = is_top ? {1'b1, {(SEG_W-1){1'b0}}} : '0;
      else          v = is_top ? {1'b0, {(SEG_W-1){1'b1}}} : '1;
    end else begin
      v = sub ? '0 : '1;
    end
    return v;
  endfunction

endpackage

// File: rtl/simd_seg.sv
module simd_seg
  import simd_pkg::*;
(
  input  logic [SEG_W-1:0] a,
  input  logic [SEG_W-1:0] b,
  input  logic             sub,
  input  logic             cin,
  output logic [SEG_W-1:0] sum,
  output logic             c_msb,
  output logic             cout
);
  logic [SEG_W-1:0] bb;
  logic [SEG_W-1:0] low;
  logic [1:0]       top;

  assign bb    = sub ? ~b : b;
  assign low   = {1'b0, a[SEG_W-2:0]} + {1'b0, bb[SEG_W-2:0]} + {{(SEG_W-1){1'b0}}, cin};
  assign c_msb = low[SEG_W-1];
  assign top   = {1'b0, a[SEG_W-1]} + {1'b0, bb[SEG_W-1]} + {1'b0, c_msb};
  assign sum   = {top[0], low[SEG_W-2:0]};
  assign cout  = top[1];
endmodule

// File: rtl/simd_sat_clamp.sv
module simd_sat_clamp
  import simd_pkg::*;
(
  input  logic [SEG_W-1:0] raw,
  input  logic             is_top,
  input  logic             signed_en,
  input  logic             sub_en,
  input  logic             neg_side,
  input  logic             hit,
  output logic [SEG_W-1:0] res
);
  assign res = clamp_byte(raw, is_top, signed_en, sub_en, neg_side, hit);
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        lane_sel,
  input  logic              sub_en,
  input  logic              signed_en,
  input  logic              sat_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W/SEG_W-1:0] sat_flag
);
  localparam int NSEG  = DATA_W / SEG_W;
  localparam int IDX_W = $clog2(NSEG);

  logic [IDX_W-1:0]  span;
  logic [NSEG-1:0]   seg_cin, seg_cout, seg_cmsb;
  logic [NSEG-1:0]   lane_start, lane_hit;
  logic [DATA_W-1:0] raw_sum, clamped;

  assign span = IDX_W'(span_mask(lane_sel, NSEG));

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    logic [IDX_W-1:0] top_k;
    logic             s_ovf, u_ovf;

    assign lane_start[k] = ((IDX_W'(k) & span) == '0);
    assign top_k         = IDX_W'(k) | span;

    if (k == 0) begin : g_first
      assign seg_cin[k] = sub_en;
    end else begin : g_rest
      assign seg_cin[k] = lane_start[k] ? sub_en : seg_cout[k-1];
    end

    simd_seg u_seg (
      .a     (op_a[k*SEG_W +: SEG_W]),
      .b     (op_b[k*SEG_W +: SEG_W]),
      .sub   (sub_en),
      .cin   (seg_cin[k]),
      .sum   (raw_sum[k*SEG_W +: SEG_W]),
      .c_msb (seg_cmsb[k]),
      .cout  (seg_cout[k])
    );

    assign s_ovf       = seg_cmsb[top_k] ^ seg_cout[top_k];
    assign u_ovf       = sub_en ? ~seg_cout[top_k] : seg_cout[top_k];
    assign lane_hit[k] = sat_en && (lane_sel != LW_B64) && (signed_en ? s_ovf : u_ovf);

    simd_sat_clamp u_clamp (
      .raw       (raw_sum[k*SEG_W +: SEG_W]),
      .is_top    (top_k == IDX_W'(k)),
      .signed_en (signed_en),
      .sub_en    (sub_en),
      .neg_side  (op_a[top_k*SEG_W + SEG_W - 1]),
      .hit       (lane_hit[k]),
      .res       (clamped[k*SEG_W +: SEG_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      sat_flag  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= clamped;
        sat_flag <= lane_hit;
      end
    end
  end
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [1:0]        lane_sel,
  input logic              sub_en,
  input logic              signed_en,
  input logic              sat_en,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [DATA_W/8-1:0] sat_flag
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(sat_flag)));

  a_r7_no_flag_when_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sat_en) |=> (sat_flag == '0));

  a_r6_wide_lane_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'b11) |=> (sat_flag == '0));

  a_r7_flag_uniform_32: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'b10) |=>
      ((sat_flag[3:0] == 4'h0) || (sat_flag[3:0] == 4'hF)));

  a_r4_uadd_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && !signed_en && !sub_en) |=>
      (!sat_flag[0] || out_data[7:0] == 8'hFF));

  a_r4_usub_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && !signed_en && sub_en) |=>
      (!sat_flag[0] || out_data[7:0] == 8'h00));

  a_r1_byte_lane_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'b00 && !sub_en && !sat_en) |=>
      (out_data[15:8] == $past(op_a[15:8] + op_b[15:8])));
endmodule

bind simd_sat_adder simd_sat_adder_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_simd_sat_adder.sv
`timescale 1ns/1ps
module sim_simd_sat_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  lane_sel = '0;
  logic        sub_en = 1'b0, signed_en = 1'b0, sat_en = 1'b0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [7:0]  sat_flag;

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  simd_sat_adder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .lane_sel(lane_sel), .sub_en(sub_en), .signed_en(signed_en), .sat_en(sat_en),
    .out_valid(out_valid), .out_data(out_data), .sat_flag(sat_flag)
  );

  // Reference: {flags, data}, worked out lane by lane with integer arithmetic.
  function automatic logic [71:0] ref_op(input logic [63:0] a, input logic [63:0] b,
      input logic [1:0] ls, input logic sb, input logic sg, input logic st);
    int w = (ls == 2'b11) ? 64 : (8 << ls);
    int n = 64 / w;
    logic [63:0] res = '0;
    logic [7:0]  fl = '0;
    for (int l = 0; l < n; l++) begin
      logic [63:0] mask, ua, ub, lr;
      longint x, y, z, mx, mn;
      bit f;
      f = 0;
      if (w == 64) begin
        lr = sb ? a - b : a + b;
      end else begin
        mask = (64'h1 << w) - 1;
        ua = (a >> (l*w)) & mask;
        ub = (b >> (l*w)) & mask;
        lr = (sb ? ua - ub : ua + ub) & mask;
        if (st && sg) begin
          x  = ua[w-1] ? longint'(ua) - (longint'(1) << w) : longint'(ua);
          y  = ub[w-1] ? longint'(ub) - (longint'(1) << w) : longint'(ub);
          z  = sb ? x - y : x + y;
          mx = (longint'(1) << (w-1)) - 1;
          mn = -mx - 1;
          if (z > mx)      begin lr = 64'(mx);        f = 1; end
          else if (z < mn) begin lr = 64'(mn) & mask; f = 1; end
        end else if (st) begin
          if (!sb && (ua + ub) > mask) begin lr = mask; f = 1; end
          if (sb && ua < ub)           begin lr = '0;   f = 1; end
        end
      end
      res |= lr << (l*w);
      if (f) fl |= 8'(((16'h1 << (w/8)) - 1) << (l*w/8));
    end
    return {fl, res};
  endfunction

  function automatic string tag_of(input logic [1:0] ls, input logic sb, input logic sg, input logic st);
    if (ls == 2'b11) return "R6";
    if (!st)         return sb ? "R8" : "R2";
    return sg ? "R3" : "R4";
  endfunction

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] ls,
                        input logic sb, input logic sg, input logic st);
    logic [71:0] e;
    e = ref_op(a, b, ls, sb, sg, st);
    @(negedge clk);
    op_a = a; op_b = b; lane_sel = ls; sub_en = sb; signed_en = sg; sat_en = st;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R9", {71'd0, out_valid}, 72'd1);
    check({sat_flag, out_data} === e, tag_of(ls, sb, sg, st), {sat_flag, out_data}, e);
  endtask

  task automatic idle_check();
    logic [71:0] held;
    held = {sat_flag, out_data};
    @(negedge clk);
    op_a = ~op_a;
    @(negedge clk);
    check(out_valid === 1'b0 && {sat_flag, out_data} === held, "R9",
          {sat_flag, out_data}, held);
  endtask

  function automatic logic [63:0] corner(input int i);
    case (i)
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h7F7F_7F7F_7F7F_7F7F;
      3: return 64'h8080_8080_8080_8080;
      4: return 64'h7FFF_FFFF_8000_0000;
      default: return 64'h0001_0001_0001_0001;
    endcase
  endfunction

  function automatic logic [63:0] next_rng(input logic [63:0] s);
    logic [63:0] t = s;
    t ^= t << 13; t ^= t >> 7; t ^= t << 17;
    return t;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs held clear during reset
    check(out_valid === 1'b0 && out_data === '0 && sat_flag === '0, "R10",
          {sat_flag, out_data}, 72'd0);
    rst_n = 1'b1;

    // Directed cases named by requirement
    run_op(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 2'b00, 0, 0, 0); // R1 no carry into byte 1
    run_op(64'h7F00_0000_0000_0000, 64'h0100_0000_0000_0000, 2'b00, 0, 1, 1); // R3 +127 clamp
    run_op(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 2'b01, 1, 0, 1); // R4 unsigned underflow -> 0
    run_op(64'h0000_0000_1000_0000, 64'h0000_0000_2000_0000, 2'b10, 0, 1, 1); // R5 in range, no flag
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 0, 0, 1); // R6 wide wrap
    run_op(64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 2'b10, 1, 1, 1); // R7 flags 4'hF
    idle_check();

    // Sweep: every control combination over corner and random operands
    for (int c = 0; c < 32; c++) begin
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          run_op(corner(i), corner(j), c[4:3], c[2], c[1], c[0]);
      for (int r = 0; r < 20; r++) begin
        logic [63:0] ra;
        rng = next_rng(rng); ra = rng;
        rng = next_rng(rng);
        run_op(ra, rng, c[4:3], c[2], c[1], c[0]);
      end
      idle_check();
    end

    // R10: reset in mid-run clears outputs again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0 && out_data === '0 && sat_flag === '0, "R10",
          {sat_flag, out_data}, 72'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule